// File: doc/BRIEF.md
# Burst-Mode Standby Controller

This block governs the light-load burst mode of a quasi-resonant flyback controller. It watches four digitised feedback comparator flags and the present valley-count setting. It decides when the converter drops into burst mode, when switching is gated on and off while in that mode, and when to return to normal operation. The analog comparators and the normal-mode switching logic sit outside this block.

Entry is qualified three ways. Feedback must be below the entry level, the valley counter must sit at its top value, and both must hold for an unbroken blanking window. While burst mode is active, a hysteretic gate enables switching when feedback climbs above the burst-on level and disables it when feedback sinks below the burst-off level. While enabled, a fixed-period timer turns the gate on. The gate turns off at the reduced-current trip or at the duty limit, whichever comes first. A feedback excursion above the exit level leaves burst mode at once. Leaving burst mode restores the full current limit and emits a one-cycle request that forces the valley counter back to 1.

Top module: `burst_standby_ctrl`

## Requirements
- R1: After an active-low asynchronous reset, burst_active_o=0, pulse_en_o=1, gate_o=0, reduced_limit_o=0 and valley_rst_o=0.
- R2: burst_active_o rises after the clock edge on which fb_below_entry_i=1 and valley_cnt_i=VALLEY_MAX have both been sampled on BLANK_TICKS consecutive edges.
- R3: If either entry condition is absent on any edge, the blanking count restarts, so BLANK_TICKS fresh consecutive qualifying edges are again needed.
- R4: On entry pulse_en_o goes to 0. In burst mode, fb_above_on_i=1 sets it to 1, otherwise fb_below_off_i=1 clears it to 0, otherwise it holds.
- R5: While in burst mode with pulse_en_o=1, gate_o is turned on by a timer every PERIOD_TICKS cycles, the first turn-on on the first enabled edge. It stays high for at most DUTY_TICKS cycles.
- R6: cs_trip_i=1 sampled while gate_o is high, on an edge other than a timer turn-on, clears gate_o after that edge.
- R7: With burst mode active, fb_above_exit_i=1 clears burst_active_o after that single edge. It also clears gate_o and sets pulse_en_o to 1, and valley_rst_o is high for exactly that one following cycle.
- R8: reduced_limit_o equals burst_active_o in every cycle.
- R9: Outside burst mode, gate_o stays 0 and pulse_en_o stays 1 whatever the burst-on, burst-off, exit and trip flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_below_entry_i | input | 1 | Feedback below burst entry level |
| fb_above_on_i | input | 1 | Feedback above burst-on level |
| fb_below_off_i | input | 1 | Feedback below burst-off level |
| fb_above_exit_i | input | 1 | Feedback above burst exit level |
| valley_cnt_i | input | VALLEY_W | Present valley counter value |
| cs_trip_i | input | 1 | Reduced-current sense trip |
| burst_active_o | output | 1 | Burst mode active |
| pulse_en_o | output | 1 | Switching enabled |
| gate_o | output | 1 | Burst-mode gate request |
| reduced_limit_o | output | 1 | Select reduced current limit |
| valley_rst_o | output | 1 | One-cycle request to force valley counter to 1 |

## Verification
The bench interrupts the entry window on its last cycle and checks that entry comes only after a full fresh window. A design that kept the partial count would enter early. It checks that entry switches pulse_en_o off and that the first gate pulse waits for the burst-on flag. It checks the exact gate-high length and period, so an off-by-one duty counter or a missing timer wrap shows up. Trips are applied mid-pulse and on exit edges, where a design that lets a pulse leak out after exit or loses the valley reset pulse would differ from the bench model.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_BURST  = 1'b1
  } mode_e;
endpackage

// File: rtl/bsc_entry_qual.sv
module bsc_entry_qual #(
  parameter int VALLEY_W    = 3,
  parameter int VALLEY_MAX  = 7,
  parameter int BLANK_TICKS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                below_entry_i,
  input  logic [VALLEY_W-1:0] valley_i,
  output logic                enter_o
);
  localparam int CW = $clog2(BLANK_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          qual;

  assign qual    = arm_i && below_entry_i && (valley_i == VALLEY_W'(VALLEY_MAX));
  assign enter_o = qual && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!qual)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bsc_hyst_gate.sv
module bsc_hyst_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic burst_i,
  input  logic enter_i,
  input  logic exit_i,
  input  logic on_i,
  input  logic off_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                en_q <= 1'b1;
    else if (enter_i)           en_q <= 1'b0;
    else if (!burst_i || exit_i) en_q <= 1'b1;
    else if (on_i)              en_q <= 1'b1;
    else if (off_i)             en_q <= 1'b0;
  end

  assign en_o = en_q;
endmodule

// File: rtl/bsc_pulse_gen.sv
module bsc_pulse_gen #(
  parameter int PERIOD_TICKS = 8,
  parameter int DUTY_TICKS   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic trip_i,
  output logic gate_o
);
  localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] PH_OFF  = PW'(DUTY_TICKS);

  logic [PW-1:0] ph_q;
  logic          gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      gate_q <= 1'b0;
    end else if (!run_i) begin
      ph_q   <= '0;
      gate_q <= 1'b0;
    end else if (ph_q == '0) begin
      ph_q   <= PW'(1);
      gate_q <= 1'b1;
    end else begin
      ph_q   <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      gate_q <= gate_q && !trip_i && (ph_q != PH_OFF);
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/burst_standby_ctrl.sv
module burst_standby_ctrl #(
  parameter int VALLEY_W     = 3,
  parameter int VALLEY_MAX   = 7,
  parameter int BLANK_TICKS  = 1200000,
  parameter int PERIOD_TICKS = 962,
  parameter int DUTY_TICKS   = 481
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fb_below_entry_i,
  input  logic                fb_above_on_i,
  input  logic                fb_below_off_i,
  input  logic                fb_above_exit_i,
  input  logic [VALLEY_W-1:0] valley_cnt_i,
  input  logic                cs_trip_i,
  output logic                burst_active_o,
  output logic                pulse_en_o,
  output logic                gate_o,
  output logic                reduced_limit_o,
  output logic                valley_rst_o
);
  import bsc_pkg::*;

  mode_e mode_q;
  logic  in_burst, enter, exit_now, sw_en, run, vrst_q;

  assign in_burst = (mode_q == MODE_BURST);
  assign exit_now = in_burst && fb_above_exit_i;

  bsc_entry_qual #(
    .VALLEY_W(VALLEY_W), .VALLEY_MAX(VALLEY_MAX), .BLANK_TICKS(BLANK_TICKS)
  ) u_entry (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(!in_burst),
    .below_entry_i(fb_below_entry_i), .valley_i(valley_cnt_i), .enter_o(enter)
  );

  bsc_hyst_gate u_hyst (
    .clk_i(clk_i), .rst_ni(rst_ni), .burst_i(in_burst), .enter_i(enter),
    .exit_i(exit_now), .on_i(fb_above_on_i), .off_i(fb_below_off_i), .en_o(sw_en)
  );

  assign run = in_burst && sw_en && !exit_now;

  bsc_pulse_gen #(
    .PERIOD_TICKS(PERIOD_TICKS), .DUTY_TICKS(DUTY_TICKS)
  ) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .trip_i(cs_trip_i), .gate_o(gate_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      vrst_q <= 1'b0;
    end else begin
      vrst_q <= exit_now;
      if (exit_now)   mode_q <= MODE_NORMAL;
      else if (enter) mode_q <= MODE_BURST;
    end
  end

  assign burst_active_o  = in_burst;
  assign reduced_limit_o = in_burst;
  assign pulse_en_o      = sw_en;
  assign valley_rst_o    = vrst_q;
endmodule

// File: rtl/burst_standby_ctrl_chk.sv
module burst_standby_ctrl_chk #(
  parameter int DUTY_TICKS = 481
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fb_below_entry_i,
  input logic fb_above_on_i,
  input logic fb_above_exit_i,
  input logic burst_active_o,
  input logic pulse_en_o,
  input logic gate_o,
  input logic valley_rst_o
);
  localparam int HW = $clog2(DUTY_TICKS + 2);
  logic [HW-1:0] high_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     high_cnt_q <= '0;
    else if (gate_o) high_cnt_q <= high_cnt_q + 1'b1;
    else             high_cnt_q <= '0;
  end

  AST_GATE_ONLY_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> burst_active_o); // R9
  AST_IDLE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_active_o |-> pulse_en_o); // R9
  AST_EXIT_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_active_o && fb_above_exit_i) |=> (!burst_active_o && valley_rst_o && !gate_o)); // R7
  AST_VRST_ONLY_ON_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valley_rst_o |-> $fell(burst_active_o)); // R7
  AST_ENTRY_SWITCH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_active_o) |-> !pulse_en_o); // R4
  AST_ON_LEVEL_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_active_o && fb_above_on_i && !fb_above_exit_i) |=> pulse_en_o); // R4
  AST_ENTRY_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_active_o) |-> $past(fb_below_entry_i)); // R2
  AST_DUTY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_cnt_q <= HW'(DUTY_TICKS)); // R5
endmodule

bind burst_standby_ctrl burst_standby_ctrl_chk #(.DUTY_TICKS(DUTY_TICKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fb_below_entry_i(fb_below_entry_i),
  .fb_above_on_i(fb_above_on_i), .fb_above_exit_i(fb_above_exit_i),
  .burst_active_o(burst_active_o), .pulse_en_o(pulse_en_o), .gate_o(gate_o),
  .valley_rst_o(valley_rst_o)
);

// File: tb/burst_standby_ctrl_bench.sv
module burst_standby_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 16;
  localparam int PER   = 8;
  localparam int DUTY  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bl = 1'b0, on = 1'b0, off = 1'b0, ex = 1'b0, trip = 1'b0;
  logic [2:0] vc = 3'd1;
  logic burst, pen, gate, rlim, vrst;

  int checks = 0;
  int errors = 0;

  // bench model state
  bit m_burst = 0, m_sw = 1, m_gate = 0, m_vrst = 0;
  int m_blank = 0, m_ph = 0;

  burst_standby_ctrl #(
    .VALLEY_W(3), .VALLEY_MAX(7), .BLANK_TICKS(BLANK),
    .PERIOD_TICKS(PER), .DUTY_TICKS(DUTY)
  ) u_burst_standby_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .fb_below_entry_i(bl), .fb_above_on_i(on),
    .fb_below_off_i(off), .fb_above_exit_i(ex), .valley_cnt_i(vc), .cs_trip_i(trip),
    .burst_active_o(burst), .pulse_en_o(pen), .gate_o(gate),
    .reduced_limit_o(rlim), .valley_rst_o(vrst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit qual_fn(bit b, bit in_burst, logic [2:0] v);
    return !in_burst && b && (v == 3'd7);
  endfunction

  task automatic model_edge();
    bit ext, ent, run, cnd;
    ext = m_burst && ex;
    cnd = qual_fn(bl, m_burst, vc);
    ent = cnd && (m_blank == BLANK - 1);
    run = m_burst && m_sw && !ext;
    m_blank = !cnd ? 0 : ((m_blank == BLANK - 1) ? m_blank : m_blank + 1);
    if (ent) m_sw = 0;
    else if (!m_burst || ext) m_sw = 1;
    else if (on) m_sw = 1;
    else if (off) m_sw = 0;
    if (!run) begin m_ph = 0; m_gate = 0; end
    else if (m_ph == 0) begin m_ph = 1; m_gate = 1; end
    else begin
      m_gate = m_gate && !trip && (m_ph != DUTY);
      m_ph = (m_ph == PER - 1) ? 0 : m_ph + 1;
    end
    m_vrst = ext;
    if (ext) m_burst = 0;
    else if (ent) m_burst = 1;
  endtask

  task automatic step(input bit b, input bit o, input bit f, input bit x,
                      input logic [2:0] v, input bit t);
    bit tripped;
    bl = b; on = o; off = f; ex = x; vc = v; trip = t;
    tripped = t && m_gate;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(burst == m_burst, "R2 burst_active", burst, m_burst);
    check(pen == m_sw, "R4 pulse_en", pen, m_sw);
    if (!m_burst) check(gate == m_gate, "R9 gate idle", gate, m_gate);
    else if (tripped) check(gate == m_gate, "R6 gate trip", gate, m_gate);
    else check(gate == m_gate, "R5 gate timing", gate, m_gate);
    check(rlim == burst, "R8 reduced_limit", rlim, burst);
    check(vrst == m_vrst, "R7 valley_rst", vrst, m_vrst);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(burst == 1'b0, "R1 burst", burst, 0);
    check(pen == 1'b1, "R1 pulse_en", pen, 1);
    check(gate == 1'b0, "R1 gate", gate, 0);
    check(rlim == 1'b0, "R1 reduced_limit", rlim, 0);
    check(vrst == 1'b0, "R1 valley_rst", vrst, 0);
    rst_ni = 1'b1;

    // R3: window broken on its last edge must restart
    for (int i = 0; i < BLANK - 1; i++) step(1, 0, 0, 0, 3'd7, 0);
    step(1, 0, 0, 0, 3'd6, 0);
    for (int i = 0; i < BLANK - 1; i++) step(1, 0, 0, 0, 3'd7, 0);
    check(burst == 1'b0, "R3 no early entry", burst, 0);
    step(1, 0, 0, 0, 3'd7, 0);
    check(burst == 1'b1, "R2 entry after full window", burst, 1);
    check(pen == 1'b0, "R4 entry disables switching", pen, 0);

    // R4/R5: enable and measure pulses over two periods
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 3'd7, 0);
    check(gate == 1'b0, "R5 no pulse before burst-on", gate, 0);
    step(0, 1, 0, 0, 3'd7, 0);
    hi = 0;
    for (int i = 0; i < 2 * PER; i++) begin
      step(0, 0, 0, 0, 3'd7, 0);
      if (gate) hi++;
    end
    check(hi == 2 * DUTY, "R5 high cycles in two periods", hi, 2 * DUTY);

    // R6: trip mid-pulse
    step(0, 0, 0, 0, 3'd7, 0);
    step(0, 0, 0, 0, 3'd7, 1);
    check(gate == 1'b0, "R6 trip ends pulse", gate, 0);

    // R4: burst-off level
    step(0, 0, 1, 0, 3'd7, 0);
    check(pen == 1'b0, "R4 off level", pen, 0);
    step(0, 1, 0, 0, 3'd7, 0);
    step(0, 0, 0, 0, 3'd7, 0);

    // R7: exit while gate high
    step(0, 0, 0, 1, 3'd7, 0);
    check(burst == 1'b0 && vrst == 1'b1 && pen == 1'b1 && gate == 1'b0,
          "R7 exit", {burst, vrst, pen, gate}, 4'b0110);
    step(0, 0, 0, 0, 3'd3, 0);
    check(vrst == 1'b0, "R7 single pulse", vrst, 0);

    // R9: burst flags ignored outside burst
    for (int i = 0; i < 20; i++)
      step(0, 1'($urandom), 1'($urandom), 1'($urandom), 3'd2, 1'($urandom));
    check(gate == 1'b0 && pen == 1'b1, "R9 idle outputs", {gate, pen}, 2'b01);

    // constrained random
    for (int blk = 0; blk < 120; blk++) begin
      bit quiet = ($urandom % 3) != 0;
      for (int i = 0; i < 40; i++) begin
        bit b = quiet ? (($urandom % 50) != 0) : 1'($urandom);
        logic [2:0] v = (($urandom % 30) == 0) ? 3'($urandom) : 3'd7;
        bit o = ($urandom % 6) == 0;
        bit f = ($urandom % 5) == 0;
        bit x = ($urandom % 90) == 0;
        bit t = ($urandom % 7) == 0;
        step(b, o, f, x, v, t);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule